// File: doc/BRIEF.md
# Programmable Masked Address Range Decoder

This block watches the address phase of a shared bus and decides whether a cycle falls inside one of two programmable windows. The memory window compares the upper address bits against a 17-bit base. A 7-bit mask can drop individual bits from the middle of that compare. The I/O window compares a 16-bit port address against a base, and a 4-bit mask can drop any of its four lowest bits. A mask with holes in it produces several disjoint sub-ranges. Such a mask is accepted and decoded literally.

Two 32-bit configuration registers hold the bases, masks and enables. They are written and read through a small configuration port that has per-byte write enables. For each address phase the block raises a registered claim one clock later. For memory claims it also reports whether the cycle is to be forwarded or trapped, based on two per-device enable inputs.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset both configuration registers read as zero and `claim`, `claimIsIo` and `claimTrap` are low.
- R2: The memory window register is selected when `cfgAddr` with its two low bits cleared equals 0x74. The I/O window register is selected when it equals 0x78. Each `cfgByteEn[b]` enables a write of data bits [8b+7:8b], and a disabled byte keeps its old value. Any other offset reads back as zero and writes nothing.
- R3: Memory register bits [14:8] and I/O register bits [31:21] always read as zero, whatever is written to them.
- R4: A memory address matches when address bits [31:22] equal memory register bits [31:22]. In addition, each address bit k in [21:15] must equal register bit k unless mask bit k-15 (memory register bits [6:0]) is 1.
- R5: A memory claim needs all of the following: command 4'b0110 or 4'b0111, memory enable (memory register bit 7) set, a match, and at least one of `fwdEnable` or `trapEnable` high. Other commands never produce a memory claim.
- R6: `claimTrap` is high only for a memory claim made while `trapEnable` was high and `fwdEnable` was low. I/O claims are always forwarded, so `claimTrap` stays low for them.
- R7: An I/O claim, which sets `claimIsIo`, needs all of the following:
  - command 4'b0010 or 4'b0011;
  - I/O enable (I/O register bit 20) set;
  - address bits [31:16] zero;
  - address bits [15:4] equal to register bits [15:4];
  - each address bit k in [3:0] equal to register bit k unless mask bit k (register bit 16+k) is 1.
- R8: A mask with holes, for example 7'b1110011 for memory or 4'b1001 for I/O, decodes exactly by the bitwise rule, giving split ranges.
- R9: The claim outputs reflect the address phase sampled at the previous rising edge while `busValid` was high, and are low otherwise. A configuration write at the same edge affects only later address phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgByteEn | input | 4 | Per-byte write enables |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Readback of the selected register (combinational) |
| busValid | input | 1 | Address phase present |
| busCmd | input | 4 | Bus command code |
| busAddr | input | 32 | Bus address |
| fwdEnable | input | 1 | Memory device forward enable |
| trapEnable | input | 1 | Memory device trap enable |
| claim | output | 1 | Registered claim of the previous address phase |
| claimIsIo | output | 1 | Claim came from the I/O window |
| claimTrap | output | 1 | Memory claim is to be trapped, not forwarded |

## Verification
The assertions assume two things about the inputs: `busCmd`, `busAddr` and the enable inputs are stable around the sampling edge, and the configuration port is driven once per cycle at most. The bench meets this by changing all inputs on the falling edge only. It compares every cycle against a bit-by-bit behavioural model. Its stimulus mixes directed windows, masks with holes, same-edge configuration writes and a long stretch of random addresses biased toward the programmed bases, so that hits and near misses both occur.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int DATA_BYTES = 4;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef struct packed {
    logic [DATA_BYTES-1:0] memByteWr;
    logic [DATA_BYTES-1:0] ioByteWr;
    logic                  rdSelMem;
    logic                  rdSelIo;
    logic                  memCycle;
    logic                  ioCycle;
  } decStrobes_t;
endpackage

// File: rtl/addr_dec_ctrl.sv
module addr_dec_ctrl
  import addr_dec_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] MEM_OFS = 8'h74,
  parameter logic [CFG_AW-1:0] IO_OFS  = 8'h78
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CFG_AW-1:0]     cfgAddr,
  input  logic                  cfgWrEn,
  input  logic [DATA_BYTES-1:0] cfgByteEn,
  input  logic                  busValid,
  input  logic [3:0]            busCmd,
  output decStrobes_t           strb
);
  localparam logic [CFG_AW-1:0] DWORD_MASK = ~CFG_AW'(3);

  logic hitMem, hitIo, isMemCmd, isIoCmd;

  always_comb begin
    hitMem   = (cfgAddr & DWORD_MASK) == MEM_OFS;
    hitIo    = (cfgAddr & DWORD_MASK) == IO_OFS;
    isMemCmd = (busCmd == CMD_MEM_RD) || (busCmd == CMD_MEM_WR);
    isIoCmd  = (busCmd == CMD_IO_RD) || (busCmd == CMD_IO_WR);
    strb.memByteWr = (cfgWrEn && hitMem) ? cfgByteEn : '0;
    strb.ioByteWr  = (cfgWrEn && hitIo) ? cfgByteEn : '0;
    strb.rdSelMem  = hitMem;
    strb.rdSelIo   = hitIo;
    strb.memCycle  = busValid && isMemCmd;
    strb.ioCycle   = busValid && isIoCmd;
  end

  AST_ONE_REG_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    !((|strb.memByteWr) && (|strb.ioByteWr))) else $error("two registers written"); // R2
  AST_ONE_CYCLE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.memCycle && strb.ioCycle)) else $error("cycle decoded as both kinds"); // R5
endmodule

// File: rtl/addr_dec_path.sv
module addr_dec_path
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MEM_LSB    = 15,
  parameter int MEM_MASK_W = 7,
  parameter int IO_W       = 16,
  parameter int IO_MASK_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  decStrobes_t       strb,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              fwdEnable,
  input  logic              trapEnable,
  output logic [ADDR_W-1:0] cfgRdData,
  output logic              claim,
  output logic              claimIsIo,
  output logic              claimTrap
);
  localparam int MEM_BASE_W = ADDR_W - MEM_LSB;
  localparam int MEM_EN_BIT = MEM_MASK_W;
  localparam int IO_EN_BIT  = IO_W + IO_MASK_W;
  localparam int RSVD_MEM_W = MEM_LSB - MEM_MASK_W - 1;
  localparam logic [ADDR_W-1:0] MEM_WMASK =
    {{MEM_BASE_W{1'b1}}, {RSVD_MEM_W{1'b0}}, 1'b1, {MEM_MASK_W{1'b1}}};
  localparam logic [ADDR_W-1:0] IO_WMASK =
    {{(ADDR_W-IO_EN_BIT-1){1'b0}}, {(IO_EN_BIT+1){1'b1}}};

  logic [ADDR_W-1:0]     memReg, ioReg;
  logic [MEM_BASE_W-1:0] memIgnore;
  logic [IO_W-1:0]       ioIgnore;
  logic memHit, ioHit, memClaimNext, ioClaimNext;

  // Mask fields widened to full compare width; zeros outside the maskable window
  always_comb begin
    memIgnore = {{(MEM_BASE_W-MEM_MASK_W){1'b0}}, memReg[MEM_MASK_W-1:0]};
    ioIgnore  = {{(IO_W-IO_MASK_W){1'b0}}, ioReg[IO_EN_BIT-1:IO_W]};
    memHit = ((busAddr[ADDR_W-1:MEM_LSB] ^ memReg[ADDR_W-1:MEM_LSB]) & ~memIgnore) == '0;
    ioHit  = (busAddr[ADDR_W-1:IO_W] == '0) &&
             (((busAddr[IO_W-1:0] ^ ioReg[IO_W-1:0]) & ~ioIgnore) == '0);
    memClaimNext = strb.memCycle && memReg[MEM_EN_BIT] && memHit && (fwdEnable || trapEnable);
    ioClaimNext  = strb.ioCycle && ioReg[IO_EN_BIT] && ioHit;
    cfgRdData = strb.rdSelMem ? memReg : (strb.rdSelIo ? ioReg : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReg    <= '0;
      ioReg     <= '0;
      claim     <= 1'b0;
      claimIsIo <= 1'b0;
      claimTrap <= 1'b0;
    end else begin
      for (int b = 0; b < DATA_BYTES; b++) begin
        if (strb.memByteWr[b]) memReg[8*b +: 8] <= cfgWrData[8*b +: 8] & MEM_WMASK[8*b +: 8];
        if (strb.ioByteWr[b])  ioReg[8*b +: 8]  <= cfgWrData[8*b +: 8] & IO_WMASK[8*b +: 8];
      end
      claim     <= memClaimNext || ioClaimNext;
      claimIsIo <= ioClaimNext;
      claimTrap <= memClaimNext && !fwdEnable;
    end
  end

  AST_CLAIM_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> $past(strb.memCycle || strb.ioCycle)) else $error("claim without cycle"); // R9
  AST_TRAP_IS_MEM: assert property (@(posedge clk) disable iff (!rstN)
    claimTrap |-> (claim && !claimIsIo)) else $error("trap on non-memory claim"); // R6
  AST_MEM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (claim && !claimIsIo) |-> ($past(memReg[MEM_EN_BIT]) && $past(fwdEnable || trapEnable)))
    else $error("memory claim while disabled"); // R5
  AST_IO_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    claimIsIo |-> ($past(busAddr[ADDR_W-1:IO_W]) == '0)) else $error("io claim high bits"); // R7
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdSelMem |-> (cfgRdData[MEM_LSB-1:MEM_EN_BIT+1] == '0)) else $error("reserved nonzero"); // R3
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic [3:0]        cfgByteEn,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic              busValid,
  input  logic [3:0]        busCmd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              fwdEnable,
  input  logic              trapEnable,
  output logic              claim,
  output logic              claimIsIo,
  output logic              claimTrap
);
  decStrobes_t strb;

  addr_dec_ctrl #(.CFG_AW(CFG_AW)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .busValid(busValid), .busCmd(busCmd), .strb(strb)
  );

  addr_dec_path #(.ADDR_W(ADDR_W)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData), .busAddr(busAddr),
    .fwdEnable(fwdEnable), .trapEnable(trapEnable), .cfgRdData(cfgRdData),
    .claim(claim), .claimIsIo(claimIsIo), .claimTrap(claimTrap)
  );
endmodule

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        busValid = 1'b0;
  logic [3:0]  busCmd = '0;
  logic [31:0] busAddr = '0;
  logic        fwdEnable = 1'b0;
  logic        trapEnable = 1'b0;
  logic        claim, claimIsIo, claimTrap;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string curTag = "R1";

  bit [31:0] mMem = '0, mIo = '0;
  bit eClaim, eIo, eTrap;

  always #4 clk = ~clk;

  addr_window_decoder i_addr_window_decoder (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Behavioural reference: bit-by-bit decode from the requirement text
  always @(posedge clk) begin
    bit memOk, ioOk, isMem, isIo, mc, ic;
    cycles++;
    if (!rstN) begin
      mMem = '0; mIo = '0; eClaim = 0; eIo = 0; eTrap = 0;
    end else begin
      isMem = (busCmd == 4'd6) || (busCmd == 4'd7);
      isIo  = (busCmd == 4'd2) || (busCmd == 4'd3);
      memOk = 1;
      for (int i = 15; i < 32; i++)
        if (!(i <= 21 && mMem[i-15]) && busAddr[i] != mMem[i]) memOk = 0;
      ioOk = (busAddr[31:16] == 16'h0);
      for (int i = 0; i < 16; i++)
        if (!(i < 4 && mIo[16+i]) && busAddr[i] != mIo[i]) ioOk = 0;
      mc = busValid && isMem && mMem[7] && memOk && (fwdEnable || trapEnable);
      ic = busValid && isIo && mIo[20] && ioOk;
      eClaim = mc || ic; eIo = ic; eTrap = mc && !fwdEnable;
      if (cfgWrEn) begin
        for (int b = 0; b < 4; b++) if (cfgByteEn[b]) begin
          if ((cfgAddr & 8'hFC) == 8'h74) mMem[8*b +: 8] = cfgWrData[8*b +: 8] & (32'hFFFF80FF >> (8*b));
          if ((cfgAddr & 8'hFC) == 8'h78) mIo[8*b +: 8]  = cfgWrData[8*b +: 8] & (32'h001FFFFF >> (8*b));
        end
      end
    end
    #2;
    chk(curTag, "claim", 32'(claim), 32'(eClaim));
    chk(curTag == "R4" ? "R7" : curTag, "claimIsIo", 32'(claimIsIo), 32'(eIo));
    chk(curTag == "R4" ? "R6" : curTag, "claimTrap", 32'(claimTrap), 32'(eTrap));
    chk("R2", "cfgRdData", cfgRdData,
        ((cfgAddr & 8'hFC) == 8'h74) ? mMem : (((cfgAddr & 8'hFC) == 8'h78) ? mIo : 32'h0));
  end

  always @(posedge clk) if (cycles > 150000 && !done) begin
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
    summary();
  end

  task automatic wr(logic [7:0] ofs, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    busValid = 0; cfgWrEn = 1; cfgAddr = ofs; cfgWrData = d; cfgByteEn = be;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic cyc(logic [3:0] cmd, logic [31:0] a);
    @(negedge clk);
    cfgWrEn = 0; busValid = 1; busCmd = cmd; busAddr = a;
    @(negedge clk);
    busValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    cfgAddr = 8'h74; #1 chk("R1", "mem reset", cfgRdData, 32'h0);
    cfgAddr = 8'h78; #1 chk("R1", "io reset", cfgRdData, 32'h0);
    chk("R1", "claim reset", 32'(claim), 32'h0);
    rstN = 1;

    curTag = "R2";
    wr(8'h76, 32'hA5A5_A5A5, 4'b0101);
    wr(8'h79, 32'h0000_1234, 4'b0011);
    wr(8'h70, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); cfgAddr = 8'h70; #1 chk("R2", "unmapped read", cfgRdData, 32'h0);

    curTag = "R3";
    wr(8'h74, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); cfgAddr = 8'h74; #1 chk("R3", "mem reserved", cfgRdData, 32'hFFFF_80FF);
    wr(8'h78, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); cfgAddr = 8'h78; #1 chk("R3", "io reserved", cfgRdData, 32'h001F_FFFF);

    curTag = "R4";
    wr(8'h74, 32'h1234_8080, 4'hF);
    fwdEnable = 1;
    cyc(4'd6, 32'h1234_8000); cyc(4'd7, 32'h1234_FFFF);
    cyc(4'd6, 32'h1234_0000); cyc(4'd6, 32'h1274_8000);
    wr(8'h74, 32'h1234_807F, 4'h1);
    cyc(4'd6, 32'h1200_0000); cyc(4'd6, 32'h12C0_0000);

    curTag = "R5";
    cyc(4'd12, 32'h1234_8000); cyc(4'd2, 32'h1234_8000);
    fwdEnable = 0; trapEnable = 0; cyc(4'd6, 32'h1234_8000);
    fwdEnable = 1; wr(8'h74, 32'h0000_0000, 4'h1); cyc(4'd6, 32'h1234_8000);
    wr(8'h74, 32'h0000_0080, 4'h1);

    curTag = "R6";
    fwdEnable = 0; trapEnable = 1; cyc(4'd7, 32'h1234_8000);
    fwdEnable = 1; trapEnable = 1; cyc(4'd7, 32'h1234_8000);
    fwdEnable = 1; trapEnable = 0; cyc(4'd6, 32'h1234_8000);

    curTag = "R7";
    wr(8'h78, 32'h001F_03F0, 4'h7);
    cyc(4'd2, 32'h0000_03F0); cyc(4'd3, 32'h0000_03FF);
    cyc(4'd2, 32'h0000_03E0); cyc(4'd2, 32'h0001_03F0); cyc(4'd6, 32'h0000_03F0);
    wr(8'h78, 32'h0000_03F0, 4'h7);
    cyc(4'd2, 32'h0000_03F5); cyc(4'd2, 32'h0000_03F0);

    curTag = "R8";
    wr(8'h74, 32'h0000_00F3, 4'h1);
    wr(8'h78, 32'h0019_03F6, 4'h7);
    for (int i = 0; i < 128; i++) cyc(4'd6, 32'h1234_8000 ^ (32'(i) << 15));
    for (int i = 0; i < 16; i++) cyc(4'd2, 32'h0000_03F0 | 32'(i));

    curTag = "R9";
    @(negedge clk);
    busValid = 1; busCmd = 4'd6; busAddr = 32'h1234_8000;
    cfgWrEn = 1; cfgAddr = 8'h74; cfgByteEn = 4'h1; cfgWrData = 32'h0;
    @(negedge clk);
    cfgWrEn = 0;
    @(negedge clk);
    busValid = 0;
    wr(8'h74, 32'h0000_0080, 4'h1);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      busValid = $urandom_range(0, 3) != 0;
      busCmd = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1)
        busAddr = (busCmd[2] ? 32'h1234_8000 : 32'h0000_03F0) ^ (32'd1 << $urandom_range(0, 31));
      else
        busAddr = busCmd[2] ? 32'h1234_8000 : 32'h0000_03F0 ^ 32'($urandom_range(0, 15));
      fwdEnable = 1'($urandom); trapEnable = 1'($urandom);
      cfgWrEn = $urandom_range(0, 31) == 0;
      cfgAddr = $urandom_range(0, 1) == 1 ? 8'h74 : 8'h78;
      cfgByteEn = 4'($urandom_range(1, 15));
      cfgWrData = {$urandom_range(0, 1) == 1 ? 16'h1234 : 16'h0, 16'($urandom)};
    end
    @(negedge clk); busValid = 0; cfgWrEn = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule